// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Host

This block is a byte-at-a-time SPI master with a small CPU-facing register file. Software selects one or more peripherals through a per-device select mask, sets the clock mode and bit order in a control register, and writes a byte to the data register to start a transfer. The block then shifts eight bits out on MOSI and eight bits in from MISO, raises a completion flag in the status register and, if enabled, an interrupt.

The bit clock advances one half-period for each advance event. An advance event is either a one-cycle enable pulse on the system side or an edge of an external clock input, which is first synchronized into the system domain. A fast-transfer option lets software run a chain of transfers: each read of the received byte sends that byte straight back out as the next transmit byte. A control bit holds MOSI low without stopping reception. Another control bit is a self-clearing software reset.

The engine is a three-state machine. `XS_IDLE` waits for a start and moves to `XS_LEAD` (start). `XS_LEAD` holds SCK at the idle level and moves to `XS_TRAIL` on an advance (leading edge). `XS_TRAIL` holds SCK at the active level. On an advance (trailing edge) it returns to `XS_LEAD` (next bit), or after the eighth bit it returns to `XS_IDLE` (finish). A software reset forces `XS_IDLE` from any state (abort).

Top module: `spi_host`

## Requirements
- R1: After the reset input is released, SCK is 0, every chip-select output is 1, irq is 0, and registers 0, 1 and 2 all read 0x00.
- R2: bus_addr 2 and 3 both read and write one device-select mask. Chip-select output i equals the inverse of mask bit i.
- R3: A read of bus_addr 1 returns status. Bit 7 is transfer complete, bit 6 is busy, and bits 5..0 repeat control bits 5..0. Control bit 6 does not appear in status.
- R4: A write to bus_addr 0 while idle loads the transmit byte and starts a transfer. Busy reads 1 on the next cycle. The transfer makes exactly 16 SCK edges, one per advance event. Busy clears and complete sets on the 16th edge.
- R5: SCK idles at control bit 1 (polarity). MISO is sampled on the rising edge when control bit 1 equals control bit 0 (phase), and on the falling edge otherwise. MOSI changes only on the opposite edge. With phase 0, the first bit is on MOSI before the first edge.
- R6: Control bit 6 set sends and fills bit 7 first. Cleared, it sends and fills bit 0 first. Register 0 returns the byte received, in the same order.
- R7: With control bit 3 set, MOSI stays 0 for the whole transfer, and the received byte is still captured correctly.
- R8: A write to bus_addr 0 while busy is ignored. The current transfer goes on with its original data and edge count.
- R9: Complete clears on a read strobe of bus_addr 0 and on the start of a new transfer. irq is 1 exactly when complete is 1 and control bit 5 is 1.
- R10: With control bit 4 set, a read strobe of bus_addr 0 while idle starts a new transfer whose transmit byte is the byte just received.
- R11: With control bit 2 set, each edge of ext_clk advances SCK by one half-period after synchronization, and sys_tick has no effect. With it cleared, each sys_tick pulse advances SCK.
- R12: Writing control with bit 7 set clears control, the select mask, complete and any transfer in progress on the following cycle. Software reset is then inactive again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on register 0) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sys_tick | input | 1 | Half-period advance enable from the system side |
| ext_clk | input | 1 | External bit-clock source, asynchronous |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | N_DEV | Active-low chip selects |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
A wrong state in the engine shows up first on SCK. A missed or extra transition changes the edge count, or leaves SCK away from its idle level once busy drops. These faults are visible within one advance event. A wrong bit counter or shift direction corrupts the MOSI byte collected at the sample edges, and the register 0 value read back after completion. An error in the completion or reset logic shows in the status byte and on irq on the cycle after the event that should have set or cleared them. The bench therefore rebuilds both serial bytes edge by edge in every mode and bit order, and reads status after each event.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_LEAD  = 2'd1,
        XS_TRAIL = 2'd2
    } xfer_state_e;

    // Control fields, packed so that bit positions match the register layout.
    typedef struct packed {
        logic msb_first;  // bit 6
        logic irq_en;     // bit 5
        logic fast;       // bit 4
        logic mosi_off;   // bit 3
        logic ext_sel;    // bit 2
        logic cpol;       // bit 1
        logic cpha;       // bit 0
    } ctrl_t;

    function automatic logic pick_bit(input logic [BYTE_W-1:0] b, input logic msb);
        return msb ? b[BYTE_W-1] : b[0];
    endfunction

    function automatic logic [BYTE_W-1:0] drop_bit(input logic [BYTE_W-1:0] b, input logic msb);
        return msb ? {b[BYTE_W-2:0], 1'b0} : {1'b0, b[BYTE_W-1:1]};
    endfunction

    function automatic logic [BYTE_W-1:0] take_bit(input logic [BYTE_W-1:0] b, input logic d,
                                                   input logic msb);
        return msb ? {b[BYTE_W-2:0], d} : {d, b[BYTE_W-1:1]};
    endfunction

endpackage

// File: rtl/spi_host_clksrc.sv
module spi_host_clksrc #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_tick,
    input  logic ext_clk,
    input  logic ext_sel,
    output logic adv
);
    // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its delayed copy.
    logic [SYNC_STAGES:0] chain;
    logic                 ext_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-1:0], ext_clk};
    end

    always_comb begin
        ext_edge = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
        adv      = ext_sel ? ext_edge : sys_tick;
    end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int N_DEV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [BYTE_W-1:0] rx_byte,
    output ctrl_t             ctrl,
    output logic [N_DEV-1:0]  dev_mask,
    output logic              tc,
    output logic              start,
    output logic [BYTE_W-1:0] start_byte,
    output logic              srst
);
    logic wr_data, rd_data, wr_ctrl, wr_mask;
    logic [BYTE_W-1:0] status, mask_rd;

    always_comb begin
        wr_data    = bus_wr && (bus_addr == ADDR_DATA) && !srst;
        rd_data    = bus_rd && !bus_wr && (bus_addr == ADDR_DATA) && !srst;
        wr_ctrl    = bus_wr && (bus_addr == ADDR_CTRL) && !srst;
        wr_mask    = bus_wr && bus_addr[1] && !srst;
        start      = !busy && (wr_data || (rd_data && ctrl.fast));
        start_byte = wr_data ? bus_wdata : rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl     <= '0;
            dev_mask <= '0;
            tc       <= 1'b0;
            srst     <= 1'b0;
        end else if (srst) begin
            ctrl     <= '0;
            dev_mask <= '0;
            tc       <= 1'b0;
            srst     <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                if (bus_wdata[BYTE_W-1]) srst <= 1'b1;
                else                     ctrl <= ctrl_t'(bus_wdata[BYTE_W-2:0]);
            end
            if (wr_mask) dev_mask <= bus_wdata[N_DEV-1:0];
            if (done)                  tc <= 1'b1;
            else if (start || rd_data) tc <= 1'b0;
        end
    end

    always_comb begin
        status  = {tc, busy, ctrl[5:0]};
        mask_rd = '0;
        mask_rd[N_DEV-1:0] = dev_mask;
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = rx_byte;
            ADDR_CTRL: bus_rdata = status;
            default:   bus_rdata = mask_rd;
        endcase
    end
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              adv,
    input  logic              start,
    input  logic [BYTE_W-1:0] start_byte,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              msb_first,
    input  logic              mosi_off,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              sck,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte
);
    xfer_state_e       state_q, state_d;
    logic [CNT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] tx_q, rx_q;
    logic              mosi_q;
    logic              lead_ev, trail_ev, last_bit, sample_ev, launch_ev;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:  if (start) state_d = XS_LEAD;
            XS_LEAD:  if (adv)   state_d = XS_TRAIL;
            XS_TRAIL: if (adv)   state_d = last_bit ? XS_IDLE : XS_LEAD;
            default:             state_d = XS_IDLE;
        endcase
        if (srst) state_d = XS_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // Edge classification
    always_comb begin
        lead_ev   = (state_q == XS_LEAD) && adv;
        trail_ev  = (state_q == XS_TRAIL) && adv;
        last_bit  = (bit_q == CNT_W'(BYTE_W - 1));
        sample_ev = cpha ? trail_ev : lead_ev;
        launch_ev = cpha ? lead_ev : (trail_ev && !last_bit);
        done      = trail_ev && last_bit && !srst;
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            mosi_q <= 1'b0;
        end else if (srst) begin
            bit_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            mosi_q <= 1'b0;
        end else if (start && state_q == XS_IDLE) begin
            bit_q <= '0;
            if (!cpha) begin
                mosi_q <= pick_bit(start_byte, msb_first);
                tx_q   <= drop_bit(start_byte, msb_first);
            end else begin
                tx_q   <= start_byte;
            end
        end else begin
            if (launch_ev) begin
                mosi_q <= pick_bit(tx_q, msb_first);
                tx_q   <= drop_bit(tx_q, msb_first);
            end
            if (sample_ev) rx_q  <= take_bit(rx_q, miso, msb_first);
            if (trail_ev)  bit_q <= bit_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q != XS_IDLE);
        sck     = cpol ^ (state_q == XS_TRAIL);
        mosi    = mosi_off ? 1'b0 : mosi_q;
        rx_byte = rx_q;
    end
endmodule

// File: rtl/spi_host.sv
module spi_host
    import spi_host_pkg::*;
#(
    parameter int N_DEV       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              sys_tick,
    input  logic              ext_clk,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [N_DEV-1:0]  cs_n,
    output logic              irq
);
    ctrl_t             ctrl;
    logic [N_DEV-1:0]  dev_mask;
    logic              tc, start, srst, busy, done, adv;
    logic [BYTE_W-1:0] start_byte, rx_byte;

    spi_host_regs #(.N_DEV(N_DEV)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .rx_byte(rx_byte),
        .ctrl(ctrl), .dev_mask(dev_mask), .tc(tc),
        .start(start), .start_byte(start_byte), .srst(srst)
    );

    spi_host_clksrc #(.SYNC_STAGES(SYNC_STAGES)) clksrc_i (
        .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick),
        .ext_clk(ext_clk), .ext_sel(ctrl.ext_sel), .adv(adv)
    );

    spi_host_shifter shifter_i (
        .clk(clk), .rst_n(rst_n), .srst(srst), .adv(adv),
        .start(start), .start_byte(start_byte),
        .cpol(ctrl.cpol), .cpha(ctrl.cpha), .msb_first(ctrl.msb_first),
        .mosi_off(ctrl.mosi_off), .miso(miso),
        .busy(busy), .done(done), .sck(sck), .mosi(mosi), .rx_byte(rx_byte)
    );

    for (genvar i = 0; i < N_DEV; i++) begin : g_cs
        assign cs_n[i] = ~dev_mask[i];
    end

    assign irq = tc & ctrl.irq_en;
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic       busy,
    input logic       tc,
    input logic       srst,
    input logic       adv,
    input logic       sck,
    input logic       irq,
    input logic       fast,
    input logic [6:0] ctrl_bits,
    input logic [7:0] mask_bits
);
    // R4: a data write while idle starts a transfer and clears completion
    a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && !busy && !srst) |=> (busy && !tc));

    // R4: busy ending without a reset leaves completion set
    a_r4_done_sets_tc: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(srst)) |-> tc);

    // R5: SCK moves only on advance events
    a_r5_sck_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !adv && !srst && !(bus_wr && bus_addr == 2'd1)) |=> $stable(sck));

    // R8: a data write during a transfer does not end it
    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !adv && !srst && bus_wr && bus_addr == 2'd0) |=> busy);

    // R9: the interrupt never fires without completion
    a_r9_irq_needs_tc: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tc);

    // R10: fast reload on read restarts the engine
    a_r10_fast_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 2'd0 && fast && !busy && !srst) |=> busy);

    // R12: software reset clears state on the next cycle
    a_r12_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (ctrl_bits == 7'd0 && mask_bits == 8'd0 && !busy && !tc && !srst));
endmodule

bind spi_host spi_host_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .busy(busy), .tc(tc), .srst(srst), .adv(adv), .sck(sck), .irq(irq),
    .fast(ctrl.fast), .ctrl_bits(ctrl), .mask_bits(dev_mask)
);

// File: tb/spi_host_tb_top.sv
module spi_host_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sys_tick = 1'b0, ext_clk = 1'b0;
    logic       sck, mosi, miso = 1'b0;
    logic [7:0] cs_n;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spi_host dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_tick(sys_tick), .ext_clk(ext_clk),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        finished = 1;
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            report();
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_strobe(input logic [1:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [7:0] cbyte(input bit msb, ien, fast, off, ext, cpol, cpha);
        return {1'b0, msb, ien, fast, off, ext, cpol, cpha};
    endfunction

    function automatic logic bit_at(input logic [7:0] b, input int i, input bit msb);
        return msb ? b[7-i] : b[i];
    endfunction

    // One half-period advance, from the selected source.
    task automatic advance(input bit ext);
        if (ext) begin
            @(negedge clk); ext_clk = ~ext_clk;
            repeat (4) @(negedge clk);
        end else begin
            @(negedge clk); sys_tick = 1'b1;
            @(negedge clk); sys_tick = 1'b0;
        end
    endtask

    // Runs the 16 half-periods of a started transfer, acting as the peripheral.
    task automatic run_edges(input bit cpol, cpha, msb, off, ext,
                             input logic [7:0] exp_mosi, input logic [7:0] slave,
                             input string req);
        int edges = 0, samples = 0;
        logic [7:0] got = 8'h00;
        logic [7:0] v;
        logic prev;
        bit mosi_seen_high = 0;
        miso = bit_at(slave, 0, msb);
        prev = sck;
        for (int e = 0; e < 16; e++) begin
            advance(ext);
            if (off && mosi) mosi_seen_high = 1;
            if (sck != prev) begin
                edges++;
                if ((sck && !prev) == (cpol == cpha)) begin
                    if (samples < 8) begin
                        if (msb) got[7-samples] = mosi; else got[samples] = mosi;
                    end
                    samples++;
                    if (samples < 8) miso = bit_at(slave, samples, msb);
                end
            end
            prev = sck;
            if (ext) begin
                @(negedge clk); sys_tick = 1'b1;
                @(negedge clk); sys_tick = 1'b0;
                @(negedge clk);
                check(sck == prev, {req, " R11 tick ignored"}, sck, prev);
            end
        end
        check(edges == 16, {req, " R4 edge count"}, edges, 16);
        check(samples == 8, {req, " R5 sample edges"}, samples, 8);
        check(got == (off ? 8'h00 : exp_mosi), {req, " R6 mosi byte"}, got, off ? 0 : exp_mosi);
        if (off) check(!mosi_seen_high, {req, " R7 mosi held low"}, mosi_seen_high, 0);
        peek(2'd1, v);
        check(v[7:6] == 2'b10, {req, " R4 complete/busy"}, v[7:6], 2);
        check(sck == cpol, {req, " R5 idle level"}, sck, cpol);
        peek(2'd0, v);
        check(v == slave, {req, " R6 rx byte"}, v, slave);
    endtask

    task automatic full_xfer(input bit cpol, cpha, msb, off, ext, ien, fast,
                             input logic [7:0] tx, input logic [7:0] slave, input string req);
        logic [7:0] v;
        wr_reg(2'd1, cbyte(msb, ien, fast, off, ext, cpol, cpha));
        wr_reg(2'd0, tx);
        peek(2'd1, v);
        check(v[6] == 1'b1 && v[7] == 1'b0, {req, " R4 busy after start"}, v, 8'h40);
        run_edges(cpol, cpha, msb, off, ext, tx, slave, req);
    endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(sck == 1'b0, "R1 sck", sck, 0);
        check(cs_n == 8'hFF, "R1 cs_n", cs_n, 8'hFF);
        check(irq == 1'b0, "R1 irq", irq, 0);
        for (int a = 0; a < 3; a++) begin
            peek(2'(a), v);
            check(v == 8'h00, "R1 register reads", v, 0);
        end

        // R2 select mask aliasing and active-low outputs
        wr_reg(2'd2, 8'hA5);
        check(cs_n == 8'h5A, "R2 cs_n from reg2", cs_n, 8'h5A);
        peek(2'd3, v);
        check(v == 8'hA5, "R2 reg3 alias", v, 8'hA5);
        wr_reg(2'd3, 8'h3C);
        peek(2'd2, v);
        check(v == 8'h3C, "R2 reg2 alias", v, 8'h3C);
        check(cs_n == 8'hC3, "R2 cs_n from reg3", cs_n, 8'hC3);

        // R3 status mirror of control bits 5..0
        for (int k = 0; k < 8; k++) begin
            logic [7:0] c;
            c = 8'(k * 8'h1D + 8'h07) & 8'h7F;
            wr_reg(2'd1, c);
            peek(2'd1, v);
            check(v == {2'b00, c[5:0]}, "R3 status mirror", v, {2'b00, c[5:0]});
        end

        // R4 R5 R6 sweep: all modes, both orders, several bytes
        for (int m = 0; m < 4; m++)
            for (int o = 0; o < 2; o++)
                for (int p = 0; p < 3; p++) begin
                    logic [7:0] tx, sl;
                    tx = 8'(8'h5A + p * 8'h3B + m * 8'h11);
                    sl = 8'(tx * 3 + 8'h27 + o);
                    full_xfer(m[1], m[0], o[0], 0, 0, 0, 0, tx, sl, "R4 R5 R6 sweep");
                end

        // R11 external clock source, two modes
        full_xfer(0, 1, 1, 0, 1, 0, 0, 8'hC6, 8'h39, "R11 ext mode1");
        full_xfer(1, 0, 0, 0, 1, 0, 0, 8'h81, 8'h7E, "R11 ext mode2");

        // R7 MOSI forced low, reception continues
        full_xfer(0, 0, 1, 1, 0, 0, 0, 8'hFF, 8'hB4, "R7 off mode0");
        full_xfer(1, 1, 0, 1, 0, 0, 0, 8'hA7, 8'h4D, "R7 off mode3");

        // R8 write while busy ignored
        wr_reg(2'd1, cbyte(1, 0, 0, 0, 0, 0, 0));
        wr_reg(2'd0, 8'h93);
        begin
            int edges = 0, samples = 0;
            logic [7:0] got = 8'h00;
            logic prev;
            miso = bit_at(8'h2E, 0, 1);
            prev = sck;
            for (int e = 0; e < 16; e++) begin
                if (e == 5) wr_reg(2'd0, 8'h00);
                advance(0);
                if (sck != prev) begin
                    edges++;
                    if (sck && !prev) begin
                        got[7-samples] = mosi;
                        samples++;
                        if (samples < 8) miso = bit_at(8'h2E, samples, 1);
                    end
                end
                prev = sck;
            end
            check(edges == 16, "R8 edge count", edges, 16);
            check(got == 8'h93, "R8 original data kept", got, 8'h93);
            peek(2'd0, v);
            check(v == 8'h2E, "R8 rx byte", v, 8'h2E);
        end

        // R9 interrupt and completion clearing
        full_xfer(0, 0, 1, 0, 0, 1, 0, 8'h3D, 8'hD2, "R9 irq xfer");
        check(irq == 1'b1, "R9 irq set", irq, 1);
        rd_strobe(2'd0);
        check(irq == 1'b0, "R9 irq cleared by read", irq, 0);
        peek(2'd1, v);
        check(v[7] == 1'b0, "R9 complete cleared by read", v[7], 0);
        full_xfer(0, 0, 1, 0, 0, 0, 0, 8'h11, 8'h22, "R9 no irq");
        check(irq == 1'b0, "R9 irq masked", irq, 0);
        wr_reg(2'd0, 8'h44);
        peek(2'd1, v);
        check(v[7:6] == 2'b01, "R9 complete cleared by start", v[7:6], 1);
        run_edges(0, 0, 1, 0, 0, 8'h44, 8'h55, "R9 restart");

        // R10 fast reload
        full_xfer(0, 1, 0, 0, 0, 0, 1, 8'h0F, 8'hC9, "R10 first");
        rd_strobe(2'd0);
        peek(2'd1, v);
        check(v[6] == 1'b1, "R10 reload started", v[6], 1);
        run_edges(0, 1, 0, 0, 0, 8'hC9, 8'h6A, "R10 reloaded");

        // R12 software reset mid-transfer
        wr_reg(2'd2, 8'hF0);
        wr_reg(2'd1, cbyte(1, 1, 0, 0, 0, 1, 0));
        wr_reg(2'd0, 8'h5C);
        for (int e = 0; e < 5; e++) advance(0);
        wr_reg(2'd1, 8'h80);
        @(negedge clk);
        peek(2'd1, v);
        check(v == 8'h00, "R12 status cleared", v, 0);
        peek(2'd2, v);
        check(v == 8'h00, "R12 mask cleared", v, 0);
        check(cs_n == 8'hFF, "R12 cs_n released", cs_n, 8'hFF);
        check(sck == 1'b0, "R12 sck idle", sck, 0);
        advance(0);
        check(sck == 1'b0, "R12 engine stopped", sck, 0);
        wr_reg(2'd1, cbyte(0, 0, 0, 0, 0, 1, 1));
        peek(2'd1, v);
        check(v == 8'h03, "R12 control writable after reset", v, 8'h03);

        report();
    end
endmodule